// File: doc/BRIEF.md
# Output-Disable Request Flag Register

This block watches four external request inputs that ask for the motor-timer outputs to be put into high impedance. It keeps one sticky flag per input in a 16-bit status register on a simple single-cycle register bus. A second register holds a 2-bit detection mode for each input and a sample-rate select shared by all four inputs. The four flags are ORed into one registered request line. That line drives the timer's output stage into high impedance.

Each input is first synchronised to the block clock. It is then watched either for a falling edge or for a low level that persists over a chosen number of consecutive samples. The samples are taken at a prescaled rate. Software acknowledges a flag with a two-step handshake: it first reads the flag as 1, then writes 0 to it. A request that arrives after the read therefore cannot be wiped out by a write that did not see it.

Register bus: `bus_addr` 0 selects the status register and 1 selects the control register. Writes take effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `odr_flag_reg`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0 and `hiz_req` is 0.
- R2: The flags for request inputs 3, 2, 1 and 0 sit in status bits 15, 14, 13 and 12 respectively.
- R3: Mode 00 sets a flag on a falling edge of its input. The input passes through a two-flop synchroniser first.
- R4: Mode 01, 10 and 11 set a flag only after 8, 16 or 128 consecutive samples that find the input low. Any high level on the synchronised input restarts the count, so a shorter low pulse sets nothing.
- R5: Control bits 9:8 hold a value k, and the level detectors take one sample every 2^k clock cycles.
- R6: A flag that has been set stays 1 until software clears it, even after its input returns high.
- R7: A flag clears only when 0 is written to its bit after the flag was read as 1. A write of 0 without such a read leaves the flag at 1. Each flag is armed and cleared on its own.
- R8: Writing 1 to a flag bit never sets it and never clears it.
- R9: If a detection event occurs in the same cycle as a clearing write, the flag stays 1.
- R10: Status bits 11:0 always read 0. Control bits 15:10 read 0, and writes to any of these bits are ignored.
- R11: `hiz_req` equals the OR of the four flags, registered, one clock cycle after the flags change.
- R12: The mode of input n is held in control bits [2n+1:2n]. Input 0 uses bits 1:0 and input 3 uses bits 7:6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 status, 1 control |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| req_pin | input | 4 | Asynchronous high-impedance request inputs, idle high |
| hiz_req | output | 1 | Registered OR of all flags |

## Verification
The bench writes 0 to a set flag without reading it first. A design that ignores the arming step would lose that request. It also holds an input low across a read-then-clear sequence. A design where the clear beats the event would drop a live request. Low pulses just shorter than each level length must not set a flag, and each level mode is placed on a different input. Decoding the wrong mode field, or counting to the wrong length, would then set a flag where none is expected, or set none in time. Writes of all ones check that software cannot set flags or disturb the reserved bits. A slow sample rate checks that the prescaler really stretches the level window.

// File: rtl/odr_pkg.sv
package odr_pkg;
  localparam int NPIN = 4;

  typedef enum logic [1:0] {
    DET_FALL   = 2'b00,
    DET_LOW_A  = 2'b01,
    DET_LOW_B  = 2'b10,
    DET_LOW_C  = 2'b11
  } det_mode_e;

  localparam logic ADDR_STATUS  = 1'b0;
  localparam logic ADDR_CONTROL = 1'b1;
endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/odr_prescale.sv
module odr_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    mask = ~({CNT_W{1'b1}} << sel);
    tick = ((cnt & mask) == mask);
  end
endmodule

// File: rtl/odr_detect.sv
module odr_detect
  import odr_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int LEN_A = 8,
  parameter int LEN_B = 16,
  parameter int LEN_C = 128
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_s,
  input  logic      tick,
  input  det_mode_e mode,
  output logic      evt
);
  logic             prev;
  logic [LVL_W-1:0] run_len;
  logic [LVL_W-1:0] target;
  logic             fall;
  logic             lvl_hit;

  always_comb begin
    case (mode)
      DET_LOW_A: target = LVL_W'(LEN_A);
      DET_LOW_B: target = LVL_W'(LEN_B);
      DET_LOW_C: target = LVL_W'(LEN_C);
      default:   target = LVL_W'(LEN_C);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b1;
      run_len <= '0;
    end else begin
      prev <= pin_s;
      if (pin_s)
        run_len <= '0;
      else if (tick && run_len < target)
        run_len <= run_len + 1'b1;
    end
  end

  always_comb begin
    fall    = prev & ~pin_s;
    lvl_hit = tick & ~pin_s & (run_len >= target - 1'b1);
    evt     = (mode == DET_FALL) ? fall : lvl_hit;
  end
endmodule

// File: rtl/odr_flag_reg.sv
module odr_flag_reg
  import odr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FLAG_LSB    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 2,
  parameter int LVL_W       = 8,
  parameter int LEN_A       = 8,
  parameter int LEN_B       = 16,
  parameter int LEN_C       = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   req_pin,
  output logic              hiz_req
);
  localparam int MODE_W = 2 * NPIN;
  localparam int CTL_W  = MODE_W + PRE_W;

  logic [CTL_W-1:0] ctl;
  logic [NPIN-1:0]  pin_s;
  logic [NPIN-1:0]  evt;
  logic [NPIN-1:0]  flags;
  logic [NPIN-1:0]  armed;
  logic             tick;
  logic             st_wr, st_rd;

  assign st_wr = bus_wr && (bus_addr == ADDR_STATUS);
  assign st_rd = bus_rd && (bus_addr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (rst)
      ctl <= '0;
    else if (bus_wr && bus_addr == ADDR_CONTROL)
      ctl <= bus_wdata[CTL_W-1:0];
  end

  odr_prescale #(.SEL_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctl[CTL_W-1:MODE_W]),
    .tick (tick)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    odr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (req_pin[i]),
      .dout (pin_s[i])
    );

    odr_detect #(
      .LVL_W (LVL_W),
      .LEN_A (LEN_A),
      .LEN_B (LEN_B),
      .LEN_C (LEN_C)
    ) u_det (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pin_s[i]),
      .tick  (tick),
      .mode  (det_mode_e'(ctl[2*i+1 -: 2])),
      .evt   (evt[i])
    );

    logic zero_wr;
    assign zero_wr = st_wr && !bus_wdata[FLAG_LSB+i];

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        if (evt[i])
          flags[i] <= 1'b1;
        else if (zero_wr && armed[i])
          flags[i] <= 1'b0;

        if (zero_wr)
          armed[i] <= 1'b0;
        else if (st_rd && flags[i])
          armed[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      hiz_req   <= 1'b0;
    end else begin
      hiz_req <= |flags;
      if (bus_rd) begin
        bus_rdata <= '0;
        if (bus_addr == ADDR_STATUS)
          bus_rdata[FLAG_LSB +: NPIN] <= flags;
        else
          bus_rdata[CTL_W-1:0] <= ctl;
      end
    end
  end
endmodule

// File: rtl/odr_flag_chk.sv
module odr_flag_chk #(
  parameter int NP       = 4,
  parameter int DATA_W   = 16,
  parameter int FLAG_LSB = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NP-1:0]     flags,
  input logic [NP-1:0]     armed,
  input logic [NP-1:0]     evt,
  input logic              hiz_req
);
  // R11: the request line tracks the OR of the flags one cycle late
  a_r11_hiz_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hiz_req == $past(|flags)));

  // R10: reserved status and control bits read back as zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[FLAG_LSB-1:0] == '0 || bus_rdata[DATA_W-1:10] == '0);

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R6: a flag only rises because its detector fired
    a_r6_set_by_event: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(evt[i]));

    // R7: a flag only falls after an armed write of zero
    a_r7_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(bus_wr && bus_addr == 1'b0 &&
                                !bus_wdata[FLAG_LSB+i] && armed[i]));

    // R9: a detection event always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[i]);
  end
endmodule

bind odr_flag_reg odr_flag_chk #(
  .NP       (odr_pkg::NPIN),
  .DATA_W   (DATA_W),
  .FLAG_LSB (FLAG_LSB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .flags     (flags),
  .armed     (armed),
  .evt       (evt),
  .hiz_req   (hiz_req)
);

// File: tb/sim_odr_flag_reg.sv
`timescale 1ns/1ps
module sim_odr_flag_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_addr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  req_pin = 4'hF;
  logic        hiz_req;

  int errors = 0;
  int checks = 0;
  logic pend = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  odr_flag_reg u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_pin   (req_pin),
    .hiz_req   (hiz_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard queue
  always @(posedge clk) pend <= bus_rd && !rst;
  always @(negedge clk) begin
    if (pend) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic rd(input logic a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all(input logic [15:0] cur);
    rd(1'b0, cur, "clear-arm");
    wr(1'b0, 16'h0000);
    rd(1'b0, 16'h0000, "R7 clear after read");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 hiz after reset", {15'b0, hiz_req}, 16'h0000);
    rd(1'b0, 16'h0000, "R1 status after reset");
    rd(1'b1, 16'h0000, "R1 control after reset");

    // R3 falling edge on pin 0, R7 blind write rejected
    req_pin[0] = 1'b0; idle(5); req_pin[0] = 1'b1;
    check("R11 hiz set", {15'b0, hiz_req}, 16'h0001);
    wr(1'b0, 16'h0000);
    rd(1'b0, 16'h1000, "R7 blind write keeps flag / R3 R2 pin0 bit12");
    wr(1'b0, 16'h0000);
    rd(1'b0, 16'h0000, "R7 clear after read of 1");
    check("R11 hiz cleared", {15'b0, hiz_req}, 16'h0000);

    // R2 pin 3 and pin 2 positions, R6 sticky, per-flag clear
    req_pin[3] = 1'b0; idle(5); req_pin[3] = 1'b1;
    req_pin[2] = 1'b0; idle(5); req_pin[2] = 1'b1;
    idle(5);
    rd(1'b0, 16'hC000, "R2 R6 pins 3,2 at bits 15,14");
    wr(1'b0, 16'h4000);
    rd(1'b0, 16'h4000, "R7 only bit 15 cleared");
    wr(1'b0, 16'hFFFF);
    rd(1'b0, 16'h4000, "R8 R10 write of ones");
    wr(1'b1, 16'hFFFF);
    rd(1'b1, 16'h03FF, "R10 control reserved bits");
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0000);
    rd(1'b0, 16'h0000, "R7 clear pin2");
    wr(1'b0, 16'hF000);
    rd(1'b0, 16'h0000, "R8 write 1 cannot set");

    // R4 R12 mode 01 on pin 1 (bits 3:2)
    wr(1'b1, 16'h0004);
    req_pin[1] = 1'b0; idle(5); req_pin[1] = 1'b1; idle(10);
    rd(1'b0, 16'h0000, "R4 R12 short low rejected in mode 01");
    req_pin[1] = 1'b0; idle(3);
    rd(1'b0, 16'h0000, "R4 not yet 8 samples");
    idle(15);
    rd(1'b0, 16'h2000, "R4 8 low samples set pin1");
    check("R11 hiz level", {15'b0, hiz_req}, 16'h0001);
    wr(1'b0, 16'h0000);
    rd(1'b0, 16'h2000, "R9 event with clearing write keeps flag");
    req_pin[1] = 1'b1; idle(2);
    clear_all(16'h2000);

    // R4 R12 mode 10 on pin 2 (bits 5:4)
    wr(1'b1, 16'h0020);
    req_pin[2] = 1'b0; idle(12); req_pin[2] = 1'b1; idle(5);
    rd(1'b0, 16'h0000, "R4 R12 12 lows rejected in mode 10");
    req_pin[2] = 1'b0; idle(25); req_pin[2] = 1'b1;
    rd(1'b0, 16'h4000, "R4 16 low samples set pin2");
    clear_all(16'h4000);

    // R4 R12 mode 11 on pin 3 (bits 7:6)
    wr(1'b1, 16'h00C0);
    req_pin[3] = 1'b0; idle(100);
    rd(1'b0, 16'h0000, "R4 R12 100 lows rejected in mode 11");
    idle(40); req_pin[3] = 1'b1;
    rd(1'b0, 16'h8000, "R4 128 low samples set pin3");
    clear_all(16'h8000);

    // R5 prescale k=3: sample every 8 cycles, mode 01 on pin 0
    wr(1'b1, 16'h0301);
    req_pin[0] = 1'b0; idle(30);
    rd(1'b0, 16'h0000, "R5 slow sampling not yet at 8 samples");
    idle(60); req_pin[0] = 1'b1;
    rd(1'b0, 16'h1000, "R5 slow sampling sets pin0");
    clear_all(16'h1000);
    idle(2);
    check("R11 hiz idle at end", {15'b0, hiz_req}, 16'h0000);

    idle(4);
    finish_run();
  end
endmodule